// File: doc/BRIEF.md
# Commit Thread Selector

This block decides, once per cycle, which of up to four hardware threads the commit stage of a multithreaded out-of-order core serves. Each thread presents whether it is currently enabled for commit, whether the instruction at the head of its reorder buffer is ready to retire, and that head instruction's sequence number. A thread is a candidate only when it is both enabled and ready. The block names at most one winner, as a one-hot vector and as an encoded index, and raises a flag when no thread can be served.

Three selection policies are chosen by a two-bit input. The fixed-priority policy always favours the lowest thread index. The rotating policy keeps an ordered list of thread indices, serves the first candidate found in that list and then moves the winner to the tail, so threads that were skipped gain priority. The age policy compares the head sequence numbers of all candidates and serves the oldest one, which keeps retirement close to program order across threads. Outputs follow the inputs in the same cycle; only the rotating list is stored.

Top module: `commit_thread_sel`

## Requirements
- R1: After a synchronous active-low reset the rotating list holds thread indices in the order 0, 1, 2, 3 from head to tail.
- R2: With policy_sel = 0 (fixed priority) the lowest-indexed candidate is granted.
- R3: With policy_sel = 1 (rotating) the candidate nearest the head of the list is granted; on the next clock edge it moves to the tail while the other entries keep their relative order.
- R4: With policy_sel = 2 (age) the candidate with the numerically smallest head sequence number (unsigned) is granted.
- R5: In age policy, candidates with equal sequence numbers resolve to the lower thread index.
- R6: A thread whose enable bit is 0 is never granted, whatever its ready bit or sequence number.
- R7: When no thread is both enabled and ready, no_grant is 1, grant_onehot is 0, grant_id is 0 and the rotating list keeps its order.
- R8: The rotating list changes only on a grant made under policy_sel = 1; grants under any other policy leave it unchanged.
- R9: policy_sel = 3 selects exactly as policy_sel = 0.
- R10: grant_id is the binary index of the single set bit of grant_onehot, and both follow the inputs combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| policy_sel | input | 2 | 0 fixed priority, 1 rotating, 2 age, 3 same as 0 |
| thr_enable | input | 4 | Per-thread enable for commit |
| thr_ready | input | 4 | Per-thread head-ready flag |
| head_seq | input | 64 | Per-thread head sequence number, thread i in bits [16i+15:16i] |
| grant_onehot | output | 4 | One-hot winning thread, zero when none |
| grant_id | output | 2 | Encoded winning thread, zero when none |
| no_grant | output | 1 | High when no thread is a candidate |

## Verification
The list rotation and a policy switch can coincide: a cycle granted under the rotating policy updates the list at the clock edge, while the very next cycle may select under another policy, and a later return to rotation must find the list exactly as that last rotating grant left it. The bench provokes this by changing policy_sel freely from cycle to cycle over random enable, ready and sequence patterns, with sequence numbers drawn from a narrow range so age ties are frequent. A behavioural model holding the list as a queue predicts the grant of every cycle and is compared with all three outputs before each clock edge.

// File: rtl/commit_sel_pkg.sv
// Shared policy encoding for the commit thread selector.
package commit_sel_pkg;
    typedef enum logic [1:0] {
        POL_FIXED  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_AGE    = 2'd2,
        POL_SPARE  = 2'd3
    } sel_policy_e;
endpackage

// File: rtl/commit_sel_fixed.sv
// Fixed-priority picker: returns the lowest-indexed set bit of cand.
// Assumes NUM_THR >= 2.
module commit_sel_fixed #(
    parameter int NUM_THR = 4,
    localparam int IDW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic [NUM_THR-1:0] cand,
    output logic               valid,
    output logic [IDW-1:0]     idx
);
    // Scan from the top so the lowest candidate is written last.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_THR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                valid = 1'b1;
                idx   = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/commit_sel_age.sv
// Age picker: returns the candidate with the smallest sequence number,
// lower index winning ties. Assumes sequence numbers compare unsigned.
module commit_sel_age #(
    parameter int NUM_THR = 4,
    parameter int SEQ_W   = 16,
    localparam int IDW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_THR-1:0]       cand,
    input  logic [NUM_THR*SEQ_W-1:0] seq_flat,
    output logic                     valid,
    output logic [IDW-1:0]           idx
);
    logic [SEQ_W-1:0] best_seq;
    logic [SEQ_W-1:0] win_seq;

    // Linear scan keeping the oldest so far; strict compare keeps lower index on ties.
    always_comb begin
        valid    = 1'b0;
        idx      = '0;
        best_seq = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (cand[i] && (!valid || seq_flat[i*SEQ_W +: SEQ_W] < best_seq)) begin
                valid    = 1'b1;
                idx      = IDW'(i);
                best_seq = seq_flat[i*SEQ_W +: SEQ_W];
            end
        end
    end

    // Sequence number of the reported winner, read back through the index.
    assign win_seq = seq_flat[idx*SEQ_W +: SEQ_W];

    for (genvar j = 0; j < NUM_THR; j++) begin : g_age_chk
        // R4
        age_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && cand[j]) |-> (win_seq <= seq_flat[j*SEQ_W +: SEQ_W]));
        // R5
        age_tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && cand[j] && (win_seq == seq_flat[j*SEQ_W +: SEQ_W])) |-> (idx <= IDW'(j)));
    end
endmodule

// File: rtl/commit_sel_rotate.sv
// Rotating picker: holds an ordered list of thread indices, reports the
// first candidate in list order, and on advance moves it to the tail.
// Assumes NUM_THR is a power of two so every list entry indexes cand.
module commit_sel_rotate #(
    parameter int NUM_THR = 4,
    localparam int IDW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] cand,
    input  logic               advance,
    output logic               valid,
    output logic [IDW-1:0]     idx
);
    logic [NUM_THR-1:0][IDW-1:0] order_q;
    logic [NUM_THR-1:0][IDW-1:0] order_d;
    logic [IDW-1:0]              pos;

    // Find the list position of the first candidate from the head.
    always_comb begin
        valid = 1'b0;
        pos   = '0;
        for (int p = NUM_THR - 1; p >= 0; p--) begin
            if (cand[order_q[p]]) begin
                valid = 1'b1;
                pos   = IDW'(p);
            end
        end
        idx = order_q[pos];
    end

    // Next list: entries after the winner slide up, the winner goes to the tail.
    always_comb begin
        for (int i = 0; i < NUM_THR - 1; i++) begin
            order_d[i] = (i < int'(pos)) ? order_q[i] : order_q[i+1];
        end
        order_d[NUM_THR-1] = order_q[pos];
    end

    // List register: identity order on reset, updated only on a rotating grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THR; i++) begin
                order_q[i] <= IDW'(i);
            end
        end else if (advance && valid) begin
            order_q <= order_d;
        end
    end

    // R3
    rot_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && valid) |=> (order_q[NUM_THR-1] == $past(idx)));
    // R7 R8
    rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && valid) |=> $stable(order_q));
endmodule

// File: rtl/commit_thread_sel.sv
// Commit thread selector: combines the enable and ready masks into a
// candidate set and grants one thread under the selected policy.
// Assumes inputs are stable before the clock edge; outputs are combinational.
module commit_thread_sel
    import commit_sel_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int SEQ_W   = 16,
    localparam int IDW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               policy_sel,
    input  logic [NUM_THR-1:0]       thr_enable,
    input  logic [NUM_THR-1:0]       thr_ready,
    input  logic [NUM_THR*SEQ_W-1:0] head_seq,
    output logic [NUM_THR-1:0]       grant_onehot,
    output logic [IDW-1:0]           grant_id,
    output logic                     no_grant
);
    logic [NUM_THR-1:0] cand;
    logic               fix_v, age_v, rot_v;
    logic [IDW-1:0]     fix_i, age_i, rot_i;
    logic               win_v;
    logic [IDW-1:0]     win_i;
    sel_policy_e        pol;

    assign cand = thr_enable & thr_ready;
    assign pol  = sel_policy_e'(policy_sel);

    commit_sel_fixed #(.NUM_THR(NUM_THR)) u_fixed (
        .cand (cand),
        .valid(fix_v),
        .idx  (fix_i)
    );

    commit_sel_age #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (cand),
        .seq_flat(head_seq),
        .valid   (age_v),
        .idx     (age_i)
    );

    commit_sel_rotate #(.NUM_THR(NUM_THR)) u_rotate (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand   (cand),
        .advance(pol == POL_ROTATE),
        .valid  (rot_v),
        .idx    (rot_i)
    );

    // Route the picker of the selected policy; the spare code falls back to fixed priority.
    always_comb begin
        unique case (pol)
            POL_ROTATE: begin win_v = rot_v; win_i = rot_i; end
            POL_AGE:    begin win_v = age_v; win_i = age_i; end
            default:    begin win_v = fix_v; win_i = fix_i; end
        endcase
    end

    // Drive the grant outputs, forced to zero when no thread qualifies.
    always_comb begin
        grant_onehot = '0;
        grant_id     = '0;
        if (win_v) begin
            grant_onehot[win_i] = 1'b1;
            grant_id            = win_i;
        end
        no_grant = !win_v;
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot) && (no_grant == (grant_onehot == '0)));
    // R6
    grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_onehot & ~(thr_enable & thr_ready)) == '0);
    // R7
    no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_grant == ((thr_enable & thr_ready) == '0));
    // R2 R9
    fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy_sel[1] || policy_sel[0]) && (policy_sel != 2'd1) && !no_grant
            |-> ((thr_enable & thr_ready & ((grant_onehot) - 1'b1)) == '0));
endmodule

// File: tb/commit_thread_sel_tb.sv
// Bench: behavioural model with the rotating list as a queue, compared every cycle.
module commit_thread_sel_tb_top;
    localparam int N  = 4;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    policy_sel = '0;
    logic [N-1:0]  thr_enable = '0;
    logic [N-1:0]  thr_ready = '0;
    logic [N*SW-1:0] head_seq = '0;
    logic [N-1:0]  grant_onehot;
    logic [1:0]    grant_id;
    logic          no_grant;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    int order[$];

    always #5 clk = ~clk;

    commit_thread_sel dut_i (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .thr_enable(thr_enable), .thr_ready(thr_ready), .head_seq(head_seq),
        .grant_onehot(grant_onehot), .grant_id(grant_id), .no_grant(no_grant)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, predict, compare, then advance the model list as the edge will.
    task automatic apply(input int pol, input logic [N-1:0] en, input logic [N-1:0] rd,
                         input int s0, input int s1, input int s2, input int s3,
                         input string tag);
        int seqs[N];
        int win;
        int wpos;
        logic [N-1:0] c;
        @(negedge clk);
        seqs = '{s0, s1, s2, s3};
        policy_sel = 2'(pol);
        thr_enable = en;
        thr_ready  = rd;
        for (int i = 0; i < N; i++) head_seq[i*SW +: SW] = SW'(seqs[i]);
        c = en & rd;
        win = -1;
        wpos = -1;
        if (pol == 1) begin
            for (int p = 0; p < order.size(); p++)
                if (win < 0 && c[order[p]]) begin win = order[p]; wpos = p; end
        end else if (pol == 2) begin
            for (int i = 0; i < N; i++)
                if (c[i] && (win < 0 || seqs[i] < seqs[win])) win = i;
        end else begin
            for (int i = N - 1; i >= 0; i--) if (c[i]) win = i;
        end
        #1;
        check(tag, "no_grant", int'(no_grant), (win < 0) ? 1 : 0);
        check(tag, "grant_onehot", int'(grant_onehot), (win < 0) ? 0 : (1 << win));
        check((win < 0) ? tag : "R10", "grant_id", int'(grant_id), (win < 0) ? 0 : win);
        if (wpos >= 0) begin
            order.delete(wpos);
            order.push_back(win);
        end
    endtask

    initial begin
        order = '{0, 1, 2, 3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: identity order visible through the first rotating grants
        apply(1, 4'hF, 4'hF, 0, 0, 0, 0, "R1");
        // R3: rotation with all threads ready, then skipping
        apply(1, 4'hF, 4'hF, 0, 0, 0, 0, "R3");
        apply(1, 4'hF, 4'b0101, 0, 0, 0, 0, "R3");
        apply(1, 4'hF, 4'hF, 0, 0, 0, 0, "R3");
        apply(1, 4'hF, 4'hF, 0, 0, 0, 0, "R3");
        // R7: nothing ready, list must hold
        apply(1, 4'hF, 4'h0, 0, 0, 0, 0, "R7");
        apply(1, 4'h0, 4'hF, 0, 0, 0, 0, "R7");
        apply(1, 4'hF, 4'hF, 0, 0, 0, 0, "R7");
        // R2 and R8: fixed grants do not rotate
        apply(0, 4'hF, 4'b1010, 9, 9, 9, 9, "R2");
        apply(0, 4'hF, 4'b1000, 9, 9, 9, 9, "R2");
        apply(2, 4'hF, 4'hF, 5, 3, 8, 1, "R8");
        apply(1, 4'hF, 4'hF, 0, 0, 0, 0, "R8");
        // R4, R5, R6: age selection
        apply(2, 4'hF, 4'hF, 40, 30, 20, 25, "R4");
        apply(2, 4'hF, 4'b1011, 100, 7, 3, 7, "R5");
        apply(2, 4'b1110, 4'hF, 1, 50, 60, 70, "R6");
        apply(0, 4'b0110, 4'b1001, 0, 0, 0, 0, "R6");
        apply(2, 4'hF, 4'hF, 65535, 0, 65534, 0, "R5");
        // R9: spare code behaves as fixed
        apply(3, 4'hF, 4'b1100, 0, 0, 0, 0, "R9");
        apply(3, 4'hF, 4'hF, 9, 1, 1, 1, "R9");
        // Random mix with frequent policy changes and narrow sequence range
        for (int k = 0; k < 3000; k++) begin
            int pol;
            string tg;
            pol = $urandom_range(0, 3);
            tg = (pol == 1) ? "R3" : (pol == 2) ? "R4" : (pol == 3) ? "R9" : "R2";
            apply(pol, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  $urandom_range(0, 5), $urandom_range(0, 5),
                  $urandom_range(0, 5), $urandom_range(0, 5), tg);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule